// File: doc/BRIEF.md
# Memory Hotplug Slot Register Interface

This block gives firmware a small register window through which it examines and manages a fixed set of memory slots. Firmware writes a selector that names one slot. Through the same window it then reads that slot's 64-bit base address, its 64-bit length and its proximity node as read-only dwords. A status word shows whether the slot holds memory and whether an insert or a remove event is waiting. Firmware acknowledges each event by writing a one to its flag, and it can ask the platform to eject the slot.

The platform side loads a slot descriptor when memory arrives, flags a remove request when memory should leave, and acknowledges a finished eject. A single general-purpose event line stays high while any slot has a pending event. Two write-only mailboxes pass a status-report event code and a status code back to the platform. Writing the status code fires a one-cycle report pulse that carries both codes and the selector value.

The slot count is a build-time parameter. Elaboration rejects a count above the configured maximum.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset every slot is disabled with no pending events, and the selector is 0. The read data, the event line, the eject strobe and the report pulse are all 0.
- R2: A read takes effect at one clock edge, and the data appears on the read port after that edge. Byte offsets 0, 4, 8, 12 and 16 return the selected slot's base low, base high, length low, length high and proximity node dwords.
- R3: A read of offset 20 returns the enabled flag in bit 0, the insert-pending flag in bit 1 and the remove-pending flag in bit 2. Bit 3 and all higher bits read 0.
- R4: A write to offset 20 clears the insert flag if wdata bit 1 is 1, and clears the remove flag if wdata bit 2 is 1. A bit written as 0 leaves its flag unchanged and never sets it.
- R5: A platform insert (which loads the descriptor, sets the enabled flag and sets the insert flag) or a platform remove request (which sets the remove flag) wins over a clear of the same flag in the same cycle.
- R6: A write of 1 to bit 3 at offset 20 gives, one cycle later, a one-cycle eject strobe together with the selected slot index. The slot's enabled flag clears only after the platform acknowledges the eject for that slot.
- R7: While the selector is at or above the slot count, reads of offsets 0 to 20 return 0. Writes to offset 20 then clear nothing and produce no eject strobe.
- R8: The event line is high exactly while at least one slot has an insert or remove flag pending.
- R9: Offset 24 is the selector. Offset 28 latches an event code. A write to offset 32 gives, one cycle later, a one-cycle report pulse carrying the latched event code, the written status code and the selector value.
- R10: Offsets 24 and above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write enable |
| bus_rd_i | input | 1 | Register read enable |
| bus_addr_i | input | 6 | Byte offset, dword aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| plat_ins_i | input | 1 | Platform insert: load descriptor, enable, flag insert |
| plat_rem_i | input | 1 | Platform remove request: flag remove |
| plat_ack_i | input | 1 | Platform eject acknowledge: clear enabled |
| plat_slot_i | input | IDX_W | Slot targeted by the platform inputs |
| plat_base_i | input | 64 | Base address loaded on insert |
| plat_len_i | input | 64 | Length loaded on insert |
| plat_node_i | input | 32 | Proximity node loaded on insert |
| gpe_o | output | 1 | General-purpose event line |
| eject_o | output | 1 | One-cycle eject strobe |
| eject_slot_o | output | IDX_W | Slot named by the eject strobe |
| rpt_valid_o | output | 1 | One-cycle status-report pulse |
| rpt_slot_o | output | 32 | Selector value with the report |
| rpt_event_o | output | 32 | Latched event code |
| rpt_status_o | output | 32 | Written status code |

## Verification
The bench builds the block with five slots and a maximum of eight. The slot index is therefore three bits wide with three codes that name no slot, and the out-of-range cases can be reached both inside the index width (5, 7) and far beyond it (200). An odd count also exercises the in-range compare at a boundary that is not a power of two. It uses the last real slot (4) and the first invalid one (5) for the edge checks.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    typedef struct packed {
        logic        en;
        logic        ins;
        logic        rem;
        logic [63:0] base;
        logic [63:0] len;
        logic [31:0] node;
    } slot_t;

    // dword index = byte offset >> 2
    localparam logic [3:0] W_BASE_LO = 4'd0;
    localparam logic [3:0] W_BASE_HI = 4'd1;
    localparam logic [3:0] W_LEN_LO  = 4'd2;
    localparam logic [3:0] W_LEN_HI  = 4'd3;
    localparam logic [3:0] W_NODE    = 4'd4;
    localparam logic [3:0] W_STAT    = 4'd5;
    localparam logic [3:0] W_SEL     = 4'd6;
    localparam logic [3:0] W_EVT     = 4'd7;
    localparam logic [3:0] W_STS     = 4'd8;

    localparam int B_EN    = 0;
    localparam int B_INS   = 1;
    localparam int B_REM   = 2;
    localparam int B_EJECT = 3;

endpackage

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
    import hp_slot_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ins_i,
    input  logic             rem_i,
    input  logic             ack_i,
    input  logic [IDX_W-1:0] pslot_i,
    input  logic [63:0]      base_i,
    input  logic [63:0]      len_i,
    input  logic [31:0]      node_i,
    input  logic             clr_ins_i,
    input  logic             clr_rem_i,
    input  logic [IDX_W-1:0] clr_slot_i,
    output slot_t            slots_o [NUM_SLOTS],
    output logic             any_evt_o
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        slot_t s_d, s_q;
        logic  p_hit, c_hit;

        always_comb begin
            p_hit = (pslot_i == IDX_W'(g));
            c_hit = (clr_slot_i == IDX_W'(g));
            s_d   = s_q;
            if (ack_i && p_hit) s_d.en = 1'b0;
            // firmware clears first, platform sets override
            if (clr_ins_i && c_hit) s_d.ins = 1'b0;
            if (clr_rem_i && c_hit) s_d.rem = 1'b0;
            if (rem_i && p_hit) s_d.rem = 1'b1;
            if (ins_i && p_hit) begin
                s_d.en   = 1'b1;
                s_d.ins  = 1'b1;
                s_d.base = base_i;
                s_d.len  = len_i;
                s_d.node = node_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) s_q <= '0;
            else         s_q <= s_d;
        end

        assign slots_o[g] = s_q;
    end

    always_comb begin
        any_evt_o = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            any_evt_o = any_evt_o | slots_o[i].ins | slots_o[i].rem;
        end
    end

endmodule

// File: rtl/hp_reg_port.sv
module hp_reg_port
    import hp_slot_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [5:0]       addr_i,
    input  logic [31:0]      wdata_i,
    input  slot_t            slots_i [NUM_SLOTS],
    output logic [31:0]      rdata_o,
    output logic             clr_ins_o,
    output logic             clr_rem_o,
    output logic [IDX_W-1:0] clr_slot_o,
    output logic             eject_o,
    output logic [IDX_W-1:0] eject_slot_o,
    output logic             rpt_valid_o,
    output logic [31:0]      rpt_slot_o,
    output logic [31:0]      rpt_event_o,
    output logic [31:0]      rpt_status_o,
    output logic [31:0]      sel_o
);

    typedef struct packed {
        logic [31:0]      sel;
        logic [31:0]      evt;
        logic [31:0]      rdata;
        logic             eject;
        logic [IDX_W-1:0] ej_slot;
        logic             rpt;
        logic [31:0]      rpt_slot;
        logic [31:0]      rpt_evt;
        logic [31:0]      rpt_sts;
    } port_t;

    port_t            st_d, st_q;
    logic [3:0]       word;
    logic             sel_ok;
    logic [IDX_W-1:0] idx;
    slot_t            cur;
    logic             stat_wr;

    always_comb begin
        word    = addr_i[5:2];
        sel_ok  = (st_q.sel < 32'(NUM_SLOTS));
        idx     = st_q.sel[IDX_W-1:0];
        cur     = sel_ok ? slots_i[idx] : '0;
        stat_wr = wr_i && (word == W_STAT) && sel_ok;

        st_d       = st_q;
        st_d.eject = 1'b0;
        st_d.rpt   = 1'b0;

        if (wr_i) begin
            case (word)
                W_SEL: st_d.sel = wdata_i;
                W_EVT: st_d.evt = wdata_i;
                W_STS: begin
                    st_d.rpt      = 1'b1;
                    st_d.rpt_slot = st_q.sel;
                    st_d.rpt_evt  = st_q.evt;
                    st_d.rpt_sts  = wdata_i;
                end
                default: ;
            endcase
        end

        if (stat_wr && wdata_i[B_EJECT]) begin
            st_d.eject   = 1'b1;
            st_d.ej_slot = idx;
        end

        if (rd_i) begin
            case (word)
                W_BASE_LO: st_d.rdata = cur.base[31:0];
                W_BASE_HI: st_d.rdata = cur.base[63:32];
                W_LEN_LO:  st_d.rdata = cur.len[31:0];
                W_LEN_HI:  st_d.rdata = cur.len[63:32];
                W_NODE:    st_d.rdata = cur.node;
                W_STAT:    st_d.rdata = {29'd0, cur.rem, cur.ins, cur.en};
                default:   st_d.rdata = 32'd0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign clr_ins_o    = stat_wr && wdata_i[B_INS];
    assign clr_rem_o    = stat_wr && wdata_i[B_REM];
    assign clr_slot_o   = idx;
    assign rdata_o      = st_q.rdata;
    assign eject_o      = st_q.eject;
    assign eject_slot_o = st_q.ej_slot;
    assign rpt_valid_o  = st_q.rpt;
    assign rpt_slot_o   = st_q.rpt_slot;
    assign rpt_event_o  = st_q.rpt_evt;
    assign rpt_status_o = st_q.rpt_sts;
    assign sel_o        = st_q.sel;

endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_slot_pkg::*;
#(
    parameter  int NUM_SLOTS = 4,
    parameter  int MAX_SLOTS = 32,
    localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [5:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    input  logic             plat_ins_i,
    input  logic             plat_rem_i,
    input  logic             plat_ack_i,
    input  logic [IDX_W-1:0] plat_slot_i,
    input  logic [63:0]      plat_base_i,
    input  logic [63:0]      plat_len_i,
    input  logic [31:0]      plat_node_i,
    output logic             gpe_o,
    output logic             eject_o,
    output logic [IDX_W-1:0] eject_slot_o,
    output logic             rpt_valid_o,
    output logic [31:0]      rpt_slot_o,
    output logic [31:0]      rpt_event_o,
    output logic [31:0]      rpt_status_o
);

    if (NUM_SLOTS > MAX_SLOTS || NUM_SLOTS < 1) begin : g_bad_count
        $error("hp_slot_regs: NUM_SLOTS out of range");
    end

    slot_t            slots [NUM_SLOTS];
    logic             clr_ins, clr_rem;
    logic [IDX_W-1:0] clr_slot;
    logic [31:0]      sel_w;

    hp_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ins_i      (plat_ins_i),
        .rem_i      (plat_rem_i),
        .ack_i      (plat_ack_i),
        .pslot_i    (plat_slot_i),
        .base_i     (plat_base_i),
        .len_i      (plat_len_i),
        .node_i     (plat_node_i),
        .clr_ins_i  (clr_ins),
        .clr_rem_i  (clr_rem),
        .clr_slot_i (clr_slot),
        .slots_o    (slots),
        .any_evt_o  (gpe_o)
    );

    hp_reg_port #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_port (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_i         (bus_wr_i),
        .rd_i         (bus_rd_i),
        .addr_i       (bus_addr_i),
        .wdata_i      (bus_wdata_i),
        .slots_i      (slots),
        .rdata_o      (bus_rdata_o),
        .clr_ins_o    (clr_ins),
        .clr_rem_o    (clr_rem),
        .clr_slot_o   (clr_slot),
        .eject_o      (eject_o),
        .eject_slot_o (eject_slot_o),
        .rpt_valid_o  (rpt_valid_o),
        .rpt_slot_o   (rpt_slot_o),
        .rpt_event_o  (rpt_event_o),
        .rpt_status_o (rpt_status_o),
        .sel_o        (sel_w)
    );

endmodule

// File: rtl/hp_slot_regs_chk.sv
module hp_slot_regs_chk #(
    parameter int NUM_SLOTS = 4
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        bus_wr_i,
    input logic        bus_rd_i,
    input logic [5:0]  bus_addr_i,
    input logic [31:0] bus_wdata_i,
    input logic [31:0] bus_rdata_o,
    input logic        plat_ins_i,
    input logic        plat_rem_i,
    input logic        gpe_o,
    input logic        eject_o,
    input logic        rpt_valid_o,
    input logic [31:0] sel_w
);

    // R8: the event line only rises after a platform event
    p_gpe_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gpe_o) |-> $past(plat_ins_i || plat_rem_i));

    // R4: the event line only falls after a status write
    p_gpe_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(gpe_o) |-> $past(bus_wr_i && bus_addr_i[5:2] == 4'd5));

    // R6: an eject strobe needs an in-range eject write one cycle earlier
    p_eject_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eject_o |-> $past(bus_wr_i && bus_addr_i[5:2] == 4'd5 && bus_wdata_i[3]
                          && sel_w < 32'(NUM_SLOTS)));

    // R9: a report pulse needs a status-code write one cycle earlier
    p_rpt_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rpt_valid_o |-> $past(bus_wr_i && bus_addr_i[5:2] == 4'd8));

    // R10: write-only and unused offsets read 0
    p_wo_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(bus_rd_i && bus_addr_i[5:2] >= 4'd6) |-> bus_rdata_o == 32'd0);

    // R7: an out-of-range selector reads 0
    p_oob_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(bus_rd_i && sel_w >= 32'(NUM_SLOTS)) |-> bus_rdata_o == 32'd0);

endmodule

bind hp_slot_regs hp_slot_regs_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .plat_ins_i  (plat_ins_i),
    .plat_rem_i  (plat_rem_i),
    .gpe_o       (gpe_o),
    .eject_o     (eject_o),
    .rpt_valid_o (rpt_valid_o),
    .sel_w       (sel_w)
);

// File: tb/hp_slot_regs_bench.sv
`timescale 1ns/1ps
module hp_slot_regs_bench;
    localparam int NS = 5;
    localparam int IW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr = 0, rd = 0;
    logic [5:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic p_ins = 0, p_rem = 0, p_ack = 0;
    logic [IW-1:0] p_slot = '0;
    logic [63:0] p_base = '0, p_len = '0;
    logic [31:0] p_node = '0;
    logic gpe, ej, rptv;
    logic [IW-1:0] ej_slot;
    logic [31:0] rpt_slot, rpt_evt, rpt_sts;

    always #4 clk = ~clk;

    hp_slot_regs #(.NUM_SLOTS(NS), .MAX_SLOTS(8)) u_hp_slot_regs (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .plat_ins_i(p_ins), .plat_rem_i(p_rem), .plat_ack_i(p_ack),
        .plat_slot_i(p_slot), .plat_base_i(p_base), .plat_len_i(p_len),
        .plat_node_i(p_node), .gpe_o(gpe), .eject_o(ej), .eject_slot_o(ej_slot),
        .rpt_valid_o(rptv), .rpt_slot_o(rpt_slot), .rpt_event_o(rpt_evt),
        .rpt_status_o(rpt_sts));

    int checks = 0, errors = 0;
    logic m_en [NS], m_ins [NS], m_rem [NS];
    logic last_ej, last_rpt;
    logic [IW-1:0] last_ej_slot;
    logic [31:0] rv, cur_sel;
    bit done = 0;

    function automatic logic [63:0] f_base(int s); return 64'h1_0000_0000 * (s + 1) + 64'h4000_0000 * s; endfunction
    function automatic logic [63:0] f_len(int s);  return 64'h8000_0000 + 64'h1000 * s; endfunction
    function automatic logic [31:0] f_node(int s); return 32'(s ^ 3); endfunction
    function automatic logic [31:0] f_stat(logic [31:0] s);
        if (s >= NS) return 0;
        return {29'd0, m_rem[s], m_ins[s], m_en[s]};
    endfunction
    function automatic logic f_gpe();
        logic o = 0;
        for (int i = 0; i < NS; i++) o |= m_ins[i] | m_rem[i];
        return o;
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic bwrite(logic [5:0] a, logic [31:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0;
        last_ej = ej; last_ej_slot = ej_slot; last_rpt = rptv;
        if (a == 6'd24) cur_sel = d;
        if (a == 6'd20 && cur_sel < NS) begin
            if (d[1]) m_ins[cur_sel] = 0;
            if (d[2]) m_rem[cur_sel] = 0;
        end
    endtask

    task automatic bread(logic [5:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1; addr = a;
        @(negedge clk); rd = 0; d = rdata;
    endtask

    task automatic plat(int kind, int s);
        @(negedge clk); p_slot = IW'(s);
        p_base = f_base(s); p_len = f_len(s); p_node = f_node(s);
        if (kind == 0) begin p_ins = 1; m_en[s] = 1; m_ins[s] = 1; end
        else if (kind == 1) begin p_rem = 1; m_rem[s] = 1; end
        else begin p_ack = 1; m_en[s] = 0; end
        @(negedge clk); p_ins = 0; p_rem = 0; p_ack = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        cur_sel = 0;
        for (int i = 0; i < NS; i++) begin m_en[i] = 0; m_ins[i] = 0; m_rem[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", rdata, 0); chk("R1 gpe", gpe, 0);
        chk("R1 eject", ej, 0);    chk("R1 report", rptv, 0);
        bread(6'd20, rv); chk("R1 status", rv, 0);

        // R2/R3/R8 insert every slot and read back
        for (int s = 0; s < NS; s++) plat(0, s);
        chk("R8 gpe set", gpe, 1);
        for (int s = NS - 1; s >= 0; s--) begin
            bwrite(6'd24, s);
            bread(6'd0,  rv); chk("R2 base lo", rv, f_base(s)[31:0]);
            bread(6'd4,  rv); chk("R2 base hi", rv, f_base(s)[63:32]);
            bread(6'd8,  rv); chk("R2 len lo",  rv, f_len(s)[31:0]);
            bread(6'd12, rv); chk("R2 len hi",  rv, f_len(s)[63:32]);
            bread(6'd16, rv); chk("R2 node",    rv, f_node(s));
            bread(6'd20, rv); chk("R3 status",  rv, 32'h3);
        end

        // R4 zero writes leave flags, one clears
        bwrite(6'd24, 2);
        plat(1, 2);
        bwrite(6'd20, 32'h1);
        bread(6'd20, rv); chk("R4 zero write keeps", rv, 32'h7);
        bwrite(6'd20, 32'h2);
        bread(6'd20, rv); chk("R4 clear insert", rv, 32'h5);
        bwrite(6'd20, 32'h4);
        bread(6'd20, rv); chk("R4 clear remove", rv, 32'h1);

        // R5 platform set wins over a same-cycle clear
        @(negedge clk); wr = 1; addr = 6'd20; wdata = 32'h4; p_rem = 1; p_slot = 2;
        @(negedge clk); wr = 0; p_rem = 0; m_rem[2] = 1;
        bread(6'd20, rv); chk("R5 set wins", rv, 32'h5);

        // R6 eject strobe and acknowledge
        bwrite(6'd24, 4);
        bwrite(6'd20, 32'h8);
        chk("R6 strobe", last_ej, 1); chk("R6 slot", last_ej_slot, 4);
        @(negedge clk); chk("R6 one cycle", ej, 0);
        bread(6'd20, rv); chk("R6 still enabled", rv[0], 1);
        plat(2, 4);
        bread(6'd20, rv); chk("R6 ack clears", rv[0], 0);

        // R7 out-of-range selectors
        foreach (m_en[i]) ; // no-op
        for (int k = 0; k < 3; k++) begin
            logic [31:0] bad;
            bad = (k == 0) ? 32'd5 : (k == 1) ? 32'd7 : 32'd200;
            bwrite(6'd24, bad);
            bread(6'd0,  rv); chk("R7 info zero", rv, 0);
            bread(6'd16, rv); chk("R7 node zero", rv, 0);
            bread(6'd20, rv); chk("R7 status zero", rv, 0);
            bwrite(6'd20, 32'hE);
            chk("R7 no eject", last_ej, 0);
        end
        bwrite(6'd24, 0);
        bread(6'd20, rv); chk("R7 slot0 untouched", rv, f_stat(0));
        bwrite(6'd24, 1);
        bread(6'd20, rv); chk("R7 slot1 untouched", rv, f_stat(1));

        // R9 report mailboxes
        bwrite(6'd28, 32'h0000_0103);
        bwrite(6'd32, 32'h0000_0081);
        chk("R9 pulse", last_rpt, 1); chk("R9 event", rpt_evt, 32'h103);
        chk("R9 status", rpt_sts, 32'h81); chk("R9 slot", rpt_slot, 1);
        @(negedge clk); chk("R9 one cycle", rptv, 0);

        // R10 write-only reads
        bread(6'd24, rv); chk("R10 selector", rv, 0);
        bread(6'd28, rv); chk("R10 event", rv, 0);
        bread(6'd32, rv); chk("R10 status", rv, 0);

        // random mix, R4 R5 R8
        for (int it = 0; it < 400; it++) begin
            int op, s;
            op = $urandom_range(0, 4);
            s  = $urandom_range(0, NS + 1);
            case (op)
                0: if (s < NS) plat(0, s);
                1: if (s < NS) plat(1, s);
                2: begin bwrite(6'd24, s); bwrite(6'd20, {28'd0, 1'b0, 3'($urandom_range(0, 7))}); end
                default: begin
                    bwrite(6'd24, s);
                    bread(6'd20, rv); chk("R4 random status", rv, f_stat(s));
                end
            endcase
            chk("R8 random gpe", gpe, f_gpe());
        end

        done = 1;
        summary();
    end
endmodule